// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the head of each received Ethernet frame, one byte per valid beat, and decides whether the frame should be kept. A start-of-frame marker comes with the first byte and an end-of-frame marker with the last byte. Once six destination bytes have arrived, the block raises a single-cycle decision strobe. The strobe carries two flags: whether the frame is accepted, and whether its destination missed every configured match.

The destination is classified in a fixed order.
- An all-ones destination is a broadcast. It misses only when broadcast rejection is enabled.
- A group address, or any address when the hash-everything mode is on, is looked up in a 64-bit hash table. The table is indexed by six bits of a CRC-32 over the destination bytes.
- Every other address is compared with the programmed station address.

Promiscuous mode keeps missed frames but still marks them as misses.

A separate end-of-frame strobe reports an oversize flag. The flag is raised when huge-frame mode is on and the frame length exceeds the configured maximum. The block only reads its configuration inputs; it stores no frame data.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, `dec_vld`, `dec_accept`, `dec_miss`, `end_vld` and `too_long` are all 0.
- R2: A frame of six or more bytes gives exactly one `dec_vld` pulse, in the cycle after the sixth byte is taken; later bytes of that frame give no further decision pulse.
- R3: When all six destination bytes are 0xFF, `dec_miss` equals `bcast_reject`.
- R4: A non-broadcast destination whose first byte has bit 0 set is looked up in the hash table. The CRC register starts at 0xFFFFFFFF and uses polynomial 0x04C11DB7. Each byte is shifted in least significant bit first, with no final inversion. The index is CRC bits 31:26. Index bit 5 set selects `hash_hi`, clear selects `hash_lo`. Index bits 4:0 pick the bit within that word. A clear table bit is a miss.
- R5: With `hash_all` set, a non-broadcast destination whose first byte has bit 0 clear also goes through the hash lookup of R4, not the station compare.
- R6: Any other destination is a hit only when byte 0 equals `station_hi[15:8]`, byte 1 equals `station_hi[7:0]`, and bytes 2, 3, 4 and 5 equal `station_lo` bits 31:24, 23:16, 15:8 and 7:0.
- R7: A frame whose end marker arrives on byte 1 to 5 gives one `dec_vld` pulse in the cycle after that byte, with `dec_miss` = 1.
- R8: On every decision, `dec_accept` = 1 when `dec_miss` is 0, and `dec_accept` equals `promisc` when `dec_miss` is 1.
- R9: Each byte that carries `eof` gives one `end_vld` pulse in the next cycle. With that pulse, `too_long` = 1 exactly when `huge_en` is set and the frame length in bytes exceeds `max_len`.
- R10: A beat with `sof` restarts the frame and discards any partial address. Beats with `byte_vld` that arrive outside a frame (no `sof` since the last end) produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| station_hi | input | 16 | Station address bytes 0 (high half) and 1 (low half) |
| station_lo | input | 32 | Station address bytes 2 (bits 31:24) to 5 (bits 7:0) |
| hash_lo | input | 32 | Hash table bits for indices 0 to 31 |
| hash_hi | input | 32 | Hash table bits for indices 32 to 63 |
| bcast_reject | input | 1 | Treat broadcast as a miss |
| hash_all | input | 1 | Send individual addresses through the hash table |
| promisc | input | 1 | Accept missed frames, still flagged |
| huge_en | input | 1 | Huge-frame mode, enables the oversize flag |
| max_len | input | LEN_W | Maximum frame length in bytes |
| sof | input | 1 | First byte of a frame (with byte_vld) |
| byte_vld | input | 1 | Byte beat valid |
| byte_data | input | 8 | Frame byte |
| eof | input | 1 | Last byte of a frame (with byte_vld) |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Destination matched nothing |
| end_vld | output | 1 | One-cycle end-of-frame strobe |
| too_long | output | 1 | Oversize flag, valid with end_vld |

## Verification
The embedded assertions assume several things about the inputs:
- `sof` and `eof` are only meaningful together with `byte_vld`.
- The configuration inputs stay still during the cycle a decision or end strobe is formed, since those checks compare outputs with the previous cycle's `promisc`, `bcast_reject` and `huge_en`.

The stimulus respects this. It changes configuration only between frames, drives inputs on the falling edge, and raises `sof` and `eof` only on valid beats. Random frames cover all four destination classes and both short and long lengths. Directed cases cover frame restart and stray beats outside a frame.

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      station_hi,
  input  logic [31:0]      station_lo,
  input  logic [31:0]      hash_lo,
  input  logic [31:0]      hash_hi,
  input  logic             bcast_reject,
  input  logic             hash_all,
  input  logic             promisc,
  input  logic             huge_en,
  input  logic [LEN_W-1:0] max_len,
  input  logic             sof,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             eof,
  output logic             dec_vld,
  output logic             dec_accept,
  output logic             dec_miss,
  output logic             end_vld,
  output logic             too_long
);
  localparam int          LAST_IDX = 5;
  localparam logic [31:0] POLY     = 32'h04C11DB7;

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  logic             in_frame;
  logic [LEN_W-1:0] cnt;
  logic [31:0]      crc;
  logic [7:0]       da [0:4];

  wire              beat      = byte_vld && (sof || in_frame);
  wire [LEN_W-1:0]  idx       = sof ? '0 : cnt;
  wire [31:0]       crc_nx    = crc_byte(sof ? 32'hFFFF_FFFF : crc, byte_data);
  wire              addr_done = beat && (idx == LEN_W'(LAST_IDX));
  wire              short_end = beat && eof && (idx < LEN_W'(LAST_IDX));
  wire [LEN_W:0]    len_now   = {1'b0, idx} + 1'b1;

  wire        is_bc    = &{da[0], da[1], da[2], da[3], da[4], byte_data};
  wire        use_hash = da[0][0] || hash_all;
  wire [5:0]  hidx     = crc_nx[31:26];
  wire [63:0] htab     = {hash_hi, hash_lo};
  wire        hbit     = htab[hidx];
  wire        st_match = ({da[0], da[1]} == station_hi) &&
                         ({da[2], da[3], da[4], byte_data} == station_lo);

  logic miss_c;
  always_comb begin
    if (short_end)     miss_c = 1'b1;
    else if (is_bc)    miss_c = bcast_reject;
    else if (use_hash) miss_c = !hbit;
    else               miss_c = !st_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      crc      <= '1;
    end else if (beat) begin
      in_frame <= !eof;
      cnt      <= (&idx) ? idx : idx + 1'b1;
      crc      <= crc_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (beat && idx < LEN_W'(LAST_IDX)) da[idx[2:0]] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
      end_vld    <= 1'b0;
      too_long   <= 1'b0;
    end else begin
      dec_vld <= addr_done || short_end;
      end_vld <= beat && eof;
      if (addr_done || short_end) begin
        dec_miss   <= miss_c;
        dec_accept <= !miss_c || promisc;
      end
      if (beat && eof) too_long <= huge_en && (len_now > {1'b0, max_len});
    end
  end

  a_r2_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(byte_vld));
  a_r3_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && $past(addr_done && is_bc)) |-> (dec_miss == $past(bcast_reject)));
  a_r7_short_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && $past(short_end)) |-> dec_miss);
  a_r8_hit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !dec_miss) |-> dec_accept);
  a_r8_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_miss) |-> (dec_accept == $past(promisc)));
  a_r9_end_follows: assert property (@(posedge clk) disable iff (!rst_n)
    end_vld |-> $past(byte_vld && eof));
  a_r9_toolong_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (end_vld && too_long) |-> $past(huge_en));
endmodule

// File: tb/rx_da_filter_tb_top.sv
`timescale 1ns/1ps
module rx_da_filter_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [15:0] station_hi = 0;
  logic [31:0] station_lo = 0, hash_lo = 0, hash_hi = 0;
  logic        bcast_reject = 0, hash_all = 0, promisc = 0, huge_en = 0;
  logic [15:0] max_len = 16'd1518;
  logic        sof = 0, byte_vld = 0, eof = 0;
  logic [7:0]  byte_data = 0;
  logic        dec_vld, dec_accept, dec_miss, end_vld, too_long;

  rx_da_filter #(.LEN_W(16)) dut_i (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int nbeat = 0, n_dec = 0, n_end = 0, dec_at = 0;
  logic got_miss, got_acc, got_tl;
  logic [7:0] fb [0:31];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (byte_vld) nbeat = sof ? 1 : nbeat + 1;

  always @(negedge clk) begin
    if (dec_vld) begin n_dec++; dec_at = nbeat; got_miss = dec_miss; got_acc = dec_accept; end
    if (end_vld) begin n_end++; got_tl = too_long; end
  end

  function automatic logic [31:0] m_crc();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        logic f = c[31] ^ fb[b][i];
        c = {c[30:0], 1'b0};
        if (f) c = c ^ 32'h04C11DB7;
      end
    return c;
  endfunction

  function automatic bit m_miss(int len);
    logic [63:0] t = {hash_hi, hash_lo};
    bit bc = 1;
    if (len < 6) return 1;
    for (int b = 0; b < 6; b++) if (fb[b] != 8'hFF) bc = 0;
    if (bc) return bcast_reject;
    if (fb[0][0] || hash_all) return !t[m_crc() >> 26];
    return !({fb[0], fb[1]} == station_hi && {fb[2], fb[3], fb[4], fb[5]} == station_lo);
  endfunction

  task automatic drive(int len, bit with_sof, bit with_eof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      sof = with_sof && i == 0; byte_vld = 1; byte_data = fb[i];
      eof = with_eof && i == len - 1;
    end
    @(negedge clk);
    sof = 0; byte_vld = 0; eof = 0;
    @(negedge clk);
  endtask

  task automatic run_frame(int len, string tag);
    bit em = m_miss(len);
    n_dec = 0; n_end = 0;
    drive(len, 1, 1);
    chk(n_dec == 1, {tag, " R2 decision count"}, n_dec, 1);
    chk(dec_at == (len < 6 ? len : 6), {tag, " R7 R2 decision timing"}, dec_at, len < 6 ? len : 6);
    chk(got_miss == em, {tag, " R3 R4 R5 R6 R7 miss"}, got_miss, em);
    chk(got_acc == (!em || promisc), {tag, " R8 accept"}, got_acc, !em || promisc);
    chk(n_end == 1, {tag, " R9 end count"}, n_end, 1);
    chk(got_tl == (huge_en && len > max_len), {tag, " R9 too_long"}, got_tl, huge_en && len > max_len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(!dec_vld && !end_vld && !dec_accept && !dec_miss && !too_long, "R1 reset outputs", dec_vld, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!dec_vld && !end_vld, "R1 idle after reset", end_vld, 0);

    station_hi = 16'h0A1B; station_lo = 32'h2C3D4E5F;
    for (int b = 0; b < 6; b++) fb[b] = 8'hFF;
    bcast_reject = 0; run_frame(8, "bcast pass");
    bcast_reject = 1; run_frame(8, "bcast reject");
    promisc = 1;      run_frame(8, "bcast promisc");
    promisc = 0; bcast_reject = 0;

    fb[0] = 8'h0A; fb[1] = 8'h1B; fb[2] = 8'h2C; fb[3] = 8'h3D; fb[4] = 8'h4E; fb[5] = 8'h5F;
    run_frame(6, "station hit exact6");
    hash_lo = 0; hash_hi = 0; hash_all = 1;
    run_frame(10, "R5 hash_all empty table");
    {hash_hi, hash_lo} = 64'h1 << (m_crc() >> 26);
    run_frame(10, "R5 hash_all bit set");
    hash_all = 0;
    fb[5] = 8'h50; run_frame(9, "R6 station byte5 differs");

    run_frame(3, "R7 short frame");
    run_frame(5, "R7 short frame5");

    // R10: stray beats produce nothing
    n_dec = 0; n_end = 0;
    drive(7, 0, 1);
    chk(n_dec == 0, "R10 stray decision", n_dec, 0);
    chk(n_end == 0, "R10 stray end", n_end, 0);

    // R10: partial frame then restart
    n_dec = 0; n_end = 0;
    for (int b = 0; b < 6; b++) fb[b] = 8'hFF;
    drive(4, 1, 0);
    chk(n_dec == 0, "R10 partial no decision", n_dec, 0);
    fb[0] = 8'h0A; fb[1] = 8'h1B; fb[2] = 8'h2C; fb[3] = 8'h3D; fb[4] = 8'h4E; fb[5] = 8'h5F;
    bcast_reject = 1;
    run_frame(7, "R10 restart");
    bcast_reject = 0;

    huge_en = 1; max_len = 16'd12;
    run_frame(12, "R9 at max");
    run_frame(13, "R9 over max");
    huge_en = 0;
    run_frame(13, "R9 huge off");

    for (int n = 0; n < 400; n++) begin
      int kind = $urandom % 5;
      int len  = ($urandom % 5 == 0) ? 1 + $urandom % 5 : 6 + $urandom % 20;
      station_hi = 16'($urandom); station_lo = $urandom;
      hash_lo = $urandom; hash_hi = $urandom;
      bcast_reject = 1'($urandom); hash_all = ($urandom % 4 == 0);
      promisc = 1'($urandom); huge_en = 1'($urandom);
      max_len = 16'(4 + $urandom % 22);
      for (int b = 0; b < 32; b++) fb[b] = 8'($urandom);
      case (kind)
        0: for (int b = 0; b < 6; b++) fb[b] = 8'hFF;
        1: fb[0][0] = 1;
        2, 3: begin
          station_hi[8] = 0;
          {fb[0], fb[1]} = station_hi;
          {fb[2], fb[3], fb[4], fb[5]} = station_lo;
          if (kind == 3) fb[$urandom % 6][$urandom % 7 + 1] ^= 1'b1;
        end
        default: fb[0][0] = 0;
      endcase
      if (kind == 1 && $urandom % 2 == 1) begin
        logic [63:0] t = {hash_hi, hash_lo};
        t[m_crc() >> 26] = 1'b1;
        {hash_hi, hash_lo} = t;
      end
      run_frame(len, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule